// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block connects a 32-bit processor request port to a narrow external memory bus. Each processor address is compared against a set of programmable windows. The first window that matches drives its own chip-select line. The block then stretches every external access by that window's wait count. A 16- or 32-bit processor transfer is broken into a run of 8- or 16-bit external accesses, depending on the bus width currently selected. The sub-accesses are issued in rising address order. Read data is gathered little-endian and handed back with a single ready pulse.

Window settings come in through a simple write port. A window's settings are its enable, base address, size as a power of two, and wait count. A second write port selects the bus width. Out of reset, window 0 covers the bottom of the address space and the bus is 8 bits wide, so a boot ROM at address zero can be fetched without any setup. A decision made for a transfer is frozen when the processor request is accepted. Configuration writes therefore only shape later transfers.

Top module: `ebus_csctl`

## Requirements
- R1: Window i (0 to 6) matches address A when it is enabled and A and its base agree on every bit at or above its size exponent (exponent 32 covers all addresses). A matching access drives only `ext_cs[i]`, and drives it together with exactly one of `ext_rd`/`ext_wr`. A disabled window never matches.
- R2: When several windows match, the lowest-numbered one is used.
- R3: After reset, window 0 is enabled with base 0, size exponent 16 and wait count 2, windows 1 to 6 are disabled, and the bus is 8 bits wide. Also after reset `ext_cs`, `ext_rd`, `ext_wr` and `cpu_ready` are low.
- R4: Each external sub-access lasts (W+1) cycles, where W is the window's 4-bit wait count (0 to 15). With B sub-accesses, `cpu_ready` is high (B*(W+1)+1) rising edges after the first edge that sees `cpu_req` high, counting that edge.
- R5: With W=0, each sub-access takes exactly one cycle.
- R6: On the 8-bit bus (`cfg_width16`=0), a transfer of 1, 2 or 4 bytes (`cpu_size` 0, 1, 2; 3 acts as 2) becomes 1, 2 or 4 sub-accesses at A, A+1, and so on. Write byte k travels on `ext_wdata[7:0]` with `ext_wdata[15:8]`=0 and `ext_be`=01.
- R7: On the 16-bit bus, a 2-byte transfer is one sub-access and a 4-byte transfer is two, at A and A+2, each with `ext_be`=11 and halfword k on `ext_wdata`. A byte transfer is one sub-access. It uses lane `ext_wdata[15:8]` with `ext_be`=10 when A[0]=1, and otherwise lane `[7:0]` with `ext_be`=01.
- R8: Read data is assembled little-endian into `cpu_rdata` and zero-extended above the transfer size. It is valid while `cpu_ready` is high. On the 8-bit bus, `ext_rdata[15:8]` is ignored. A 16-bit-bus byte read takes the lane chosen by A[0].
- R9: `cpu_ready` is a one-cycle pulse that comes after the last sub-access has ended. While it is high, no chip-select is active.
- R10: An address that matches no enabled window drives no chip-select, `ext_rd` or `ext_wr`. It completes after one wait of 15 (ready at edge 17) and reads as zero.
- R11: A configuration write made while a transfer is in flight leaves that transfer's chip-select, wait count and sub-access pattern unchanged, and applies from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one window's settings |
| cfg_idx | input | 3 | Window number to write |
| cfg_en | input | 1 | Window enable |
| cfg_base | input | 32 | Window base address |
| cfg_szlog | input | 6 | Window size exponent (size = 2^n bytes) |
| cfg_wait | input | 4 | Window wait count |
| cfg_width_we | input | 1 | Write the bus width |
| cfg_width16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cpu_req | input | 1 | Transfer request, held until `cpu_ready` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Transfer address (aligned to its size) |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_ready | output | 1 | Transfer complete pulse |
| cpu_rdata | output | 32 | Read data, right-aligned |
| ext_cs | output | 7 | Chip-selects, one per window |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 32 | External byte address |
| ext_be | output | 2 | External lane enables |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |

## Verification
Transfers of every size are run on both bus widths, and the sub-access addresses, lanes and write data are compared beat by beat. These runs separate the 8-bit and 16-bit splitting rules and the odd/even byte-lane choice. Two windows are made to overlap, and addresses are tried inside both windows and inside only the larger one. This separates the priority rule from plain matching, and disabling the winning window shows the fallback. The cycle counts to ready are compared across wait counts of 0, 2, 3, 5 and the unmatched 15. A mid-transfer reprogramming of the wait count then shows that the in-flight transfer keeps its old timing while the next one uses the new value.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

   // number of bytes moved by one processor transfer
   function automatic logic [2:0] bytes_of(input xfer_size_e sz);
      case (sz)
         SZ_BYTE: bytes_of = 3'd1;
         SZ_HALF: bytes_of = 3'd2;
         default: bytes_of = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/ebus_cfg_regs.sv
`timescale 1ns/1ps
module ebus_cfg_regs #(
   parameter int ADDR_W     = 32,
   parameter int NUM_CS     = 7,
   parameter int WAIT_W     = 4,
   parameter int IDX_W      = 3,
   parameter int SZ_W       = 6,
   parameter int BOOT_SZLOG = 16,
   parameter int BOOT_WAIT  = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [IDX_W-1:0]                  idx,
   input  logic                              en_in,
   input  logic [ADDR_W-1:0]                 base_in,
   input  logic [SZ_W-1:0]                   szlog_in,
   input  logic [WAIT_W-1:0]                 wait_in,
   input  logic                              width_we,
   input  logic                              width16_in,
   output logic [NUM_CS-1:0]                 rng_en,
   output logic [NUM_CS-1:0][ADDR_W-1:0]     rng_base,
   output logic [NUM_CS-1:0][SZ_W-1:0]       rng_szlog,
   output logic [NUM_CS-1:0][WAIT_W-1:0]     rng_wait,
   output logic                              width16
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_rng
      localparam bit IS_BOOT = (i == 0);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rng_en[i]    <= IS_BOOT;
            rng_base[i]  <= '0;
            rng_szlog[i] <= IS_BOOT ? SZ_W'(BOOT_SZLOG) : '0;
            rng_wait[i]  <= IS_BOOT ? WAIT_W'(BOOT_WAIT) : '1;
         end else if (we && idx == IDX_W'(i)) begin
            rng_en[i]    <= en_in;
            rng_base[i]  <= base_in;
            rng_szlog[i] <= szlog_in;
            rng_wait[i]  <= wait_in;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        width16 <= 1'b0;
      else if (width_we) width16 <= width16_in;
   end

endmodule

// File: rtl/ebus_decoder.sv
`timescale 1ns/1ps
module ebus_decoder #(
   parameter int ADDR_W = 32,
   parameter int NUM_CS = 7,
   parameter int WAIT_W = 4,
   parameter int SZ_W   = 6
) (
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_CS-1:0]             rng_en,
   input  logic [NUM_CS-1:0][ADDR_W-1:0] rng_base,
   input  logic [NUM_CS-1:0][SZ_W-1:0]   rng_szlog,
   input  logic [NUM_CS-1:0][WAIT_W-1:0] rng_wait,
   output logic                          hit,
   output logic [NUM_CS-1:0]             sel,
   output logic [WAIT_W-1:0]             wait_cnt
);

   logic [NUM_CS-1:0] match;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_match
      logic [ADDR_W-1:0] keep;
      assign keep     = {ADDR_W{1'b1}} << rng_szlog[i];
      assign match[i] = rng_en[i] && (((addr ^ rng_base[i]) & keep) == '0);
   end

   // scan from the top so the lowest index is written last and wins
   always_comb begin
      hit      = 1'b0;
      sel      = '0;
      wait_cnt = '1;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit      = 1'b1;
            sel      = NUM_CS'(1) << i;
            wait_cnt = rng_wait[i];
         end
      end
   end

endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
   import ebus_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NUM_CS = 7,
   parameter int WAIT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_wr,
   input  logic [1:0]         cpu_size,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [31:0]        cpu_wdata,
   output logic               cpu_ready,
   output logic [31:0]        cpu_rdata,
   input  logic               dec_hit,
   input  logic [NUM_CS-1:0]  dec_sel,
   input  logic [WAIT_W-1:0]  dec_wait,
   input  logic               width16,
   output logic [NUM_CS-1:0]  ext_cs,
   output logic               ext_rd,
   output logic               ext_wr,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic [1:0]         ext_be,
   output logic [15:0]        ext_wdata,
   input  logic [15:0]        ext_rdata
);

   seq_state_e        st_q;
   logic [ADDR_W-1:0] a_q;
   logic              wr_q;
   xfer_size_e        sz_q;
   logic [31:0]       wd_q;
   logic [31:0]       rd_q;
   logic              hit_q;
   logic [NUM_CS-1:0] sel_q;
   logic [WAIT_W-1:0] wait_q;
   logic [WAIT_W-1:0] wcnt_q;
   logic              w16_q;
   logic [1:0]        beat_q;
   logic [1:0]        last_q;

   xfer_size_e        sz_in;
   logic [2:0]        nbytes;
   logic [1:0]        last_d;
   logic              act;

   assign sz_in  = xfer_size_e'(cpu_size);
   assign nbytes = bytes_of(sz_in);

   always_comb begin
      if (!dec_hit)     last_d = 2'd0;
      else if (width16) last_d = (nbytes == 3'd4) ? 2'd1 : 2'd0;
      else              last_d = 2'(nbytes - 3'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         wr_q   <= 1'b0;
         sz_q   <= SZ_BYTE;
         wd_q   <= '0;
         rd_q   <= '0;
         hit_q  <= 1'b0;
         sel_q  <= '0;
         wait_q <= '0;
         wcnt_q <= '0;
         w16_q  <= 1'b0;
         beat_q <= '0;
         last_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  a_q    <= cpu_addr;
                  wr_q   <= cpu_wr;
                  sz_q   <= sz_in;
                  wd_q   <= cpu_wdata;
                  rd_q   <= '0;
                  hit_q  <= dec_hit;
                  sel_q  <= dec_sel;
                  wait_q <= dec_hit ? dec_wait : '1;
                  wcnt_q <= dec_hit ? dec_wait : '1;
                  w16_q  <= width16;
                  beat_q <= '0;
                  last_q <= last_d;
                  st_q   <= ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (wcnt_q != '0) begin
                  wcnt_q <= wcnt_q - 1'b1;
               end else begin
                  if (hit_q && !wr_q) begin
                     if (!w16_q)
                        rd_q[{beat_q, 3'b000} +: 8] <= ext_rdata[7:0];
                     else if (sz_q == SZ_BYTE)
                        rd_q[7:0] <= a_q[0] ? ext_rdata[15:8] : ext_rdata[7:0];
                     else
                        rd_q[{beat_q[0], 4'b0000} +: 16] <= ext_rdata;
                  end
                  if (beat_q == last_q) begin
                     st_q <= ST_DONE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                     wcnt_q <= wait_q;
                  end
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign act       = (st_q == ST_BEAT) && hit_q;
   assign ext_cs    = act ? sel_q : '0;
   assign ext_rd    = act && !wr_q;
   assign ext_wr    = act && wr_q;
   assign ext_addr  = a_q + (w16_q ? ADDR_W'({beat_q, 1'b0}) : ADDR_W'(beat_q));
   assign cpu_ready = (st_q == ST_DONE);
   assign cpu_rdata = rd_q;

   always_comb begin
      ext_be    = 2'b00;
      ext_wdata = '0;
      if (act) begin
         if (!w16_q) begin
            ext_be    = 2'b01;
            ext_wdata = {8'h00, wd_q[{beat_q, 3'b000} +: 8]};
         end else if (sz_q == SZ_BYTE) begin
            ext_be    = a_q[0] ? 2'b10 : 2'b01;
            ext_wdata = a_q[0] ? {wd_q[7:0], 8'h00} : {8'h00, wd_q[7:0]};
         end else begin
            ext_be    = 2'b11;
            ext_wdata = wd_q[{beat_q[0], 4'b0000} +: 16];
         end
      end
   end

endmodule

// File: rtl/ebus_csctl.sv
`timescale 1ns/1ps
module ebus_csctl #(
   parameter int ADDR_W     = 32,
   parameter int NUM_CS     = 7,
   parameter int WAIT_W     = 4,
   parameter int BOOT_SZLOG = 16,
   parameter int BOOT_WAIT  = 2,
   localparam int IDX_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int SZ_W      = $clog2(ADDR_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic               cfg_en,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [SZ_W-1:0]    cfg_szlog,
   input  logic [WAIT_W-1:0]  cfg_wait,
   input  logic               cfg_width_we,
   input  logic               cfg_width16,
   input  logic               cpu_req,
   input  logic               cpu_wr,
   input  logic [1:0]         cpu_size,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [31:0]        cpu_wdata,
   output logic               cpu_ready,
   output logic [31:0]        cpu_rdata,
   output logic [NUM_CS-1:0]  ext_cs,
   output logic               ext_rd,
   output logic               ext_wr,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic [1:0]         ext_be,
   output logic [15:0]        ext_wdata,
   input  logic [15:0]        ext_rdata
);

   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
      $error("ebus_csctl: NUM_CS must be 1..8");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
      $error("ebus_csctl: ADDR_W must be 8..64");
   end
   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_ww
      $error("ebus_csctl: WAIT_W must be 1..8");
   end
   if (BOOT_SZLOG < 0 || BOOT_SZLOG > ADDR_W) begin : g_bad_boot
      $error("ebus_csctl: BOOT_SZLOG out of range");
   end
   if (BOOT_WAIT < 0 || BOOT_WAIT >= (1 << WAIT_W)) begin : g_bad_bw
      $error("ebus_csctl: BOOT_WAIT does not fit WAIT_W");
   end

   logic [NUM_CS-1:0]             rng_en;
   logic [NUM_CS-1:0][ADDR_W-1:0] rng_base;
   logic [NUM_CS-1:0][SZ_W-1:0]   rng_szlog;
   logic [NUM_CS-1:0][WAIT_W-1:0] rng_wait;
   logic                          width16;
   logic                          dec_hit;
   logic [NUM_CS-1:0]             dec_sel;
   logic [WAIT_W-1:0]             dec_wait;

   ebus_cfg_regs #(
      .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .IDX_W(IDX_W),
      .SZ_W(SZ_W), .BOOT_SZLOG(BOOT_SZLOG), .BOOT_WAIT(BOOT_WAIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_we), .idx(cfg_idx), .en_in(cfg_en), .base_in(cfg_base),
      .szlog_in(cfg_szlog), .wait_in(cfg_wait),
      .width_we(cfg_width_we), .width16_in(cfg_width16),
      .rng_en(rng_en), .rng_base(rng_base), .rng_szlog(rng_szlog),
      .rng_wait(rng_wait), .width16(width16)
   );

   ebus_decoder #(
      .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .SZ_W(SZ_W)
   ) u_dec (
      .addr(cpu_addr), .rng_en(rng_en), .rng_base(rng_base),
      .rng_szlog(rng_szlog), .rng_wait(rng_wait),
      .hit(dec_hit), .sel(dec_sel), .wait_cnt(dec_wait)
   );

   ebus_seq #(
      .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WAIT_W(WAIT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .dec_hit(dec_hit), .dec_sel(dec_sel), .dec_wait(dec_wait),
      .width16(width16),
      .ext_cs(ext_cs), .ext_rd(ext_rd), .ext_wr(ext_wr),
      .ext_addr(ext_addr), .ext_be(ext_be), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata)
   );

endmodule

// File: rtl/ebus_csctl_chk.sv
`timescale 1ns/1ps
module ebus_csctl_chk #(
   parameter int NUM_CS = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic [NUM_CS-1:0] ext_cs,
   input logic              ext_rd,
   input logic              ext_wr,
   input logic [1:0]        ext_be
);

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ext_cs)); // R1

   AST_CS_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cs != '0) |-> (ext_rd ^ ext_wr)); // R1

   AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd || ext_wr) |-> (ext_cs != '0)); // R10

   AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr |-> (ext_be != 2'b00)); // R7

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R9

   AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> (ext_cs == '0)); // R9

   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_cs != '0) && ($past(ext_cs) != '0)) |-> $stable(ext_cs)); // R11

endmodule

bind ebus_csctl ebus_csctl_chk #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/ebus_csctl_test.sv
`timescale 1ns/1ps
module ebus_csctl_test;

   typedef struct packed {
      logic [6:0]  cs;
      logic        wr;
      logic [31:0] addr;
      logic [1:0]  be;
      logic [15:0] data;
   } beat_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic        cfg_en = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [5:0]  cfg_szlog = '0;
   logic [3:0]  cfg_wait = '0;
   logic        cfg_width_we = 1'b0;
   logic        cfg_width16 = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic [6:0]  ext_cs;
   logic        ext_rd, ext_wr;
   logic [31:0] ext_addr;
   logic [1:0]  ext_be;
   logic [15:0] ext_wdata;
   logic [15:0] ext_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // bench copy of the window table, kept from the requirements
   logic        b_en[7];
   logic [31:0] b_base[7];
   logic [5:0]  b_szlog[7];
   logic [3:0]  b_wait[7];
   bit          bus16 = 1'b0;

   beat_t exp_q[$];

   always #5 clk = ~clk;

   ebus_csctl uut (.*);

   function automatic logic [7:0] byte_at(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   assign ext_rdata = bus16 ? {byte_at({ext_addr[31:1], 1'b1}), byte_at({ext_addr[31:1], 1'b0})}
                            : {8'hEE, byte_at(ext_addr)};

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // monitor: one scoreboard pop per new external sub-access
   logic        p_strb = 1'b0;
   logic [31:0] p_addr = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if ((ext_rd || ext_wr) && (!p_strb || ext_addr != p_addr)) begin
            beat_t act_b, exp_b;
            act_b = '{cs: ext_cs, wr: ext_wr, addr: ext_addr, be: ext_be,
                      data: ext_wr ? ext_wdata : 16'h0};
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected sub-access", 64'(act_b), 64'h0);
            end else begin
               exp_b = exp_q.pop_front();
               chk(act_b == exp_b, "R6", "sub-access {cs,wr,addr,be,data}",
                   64'(act_b), 64'(exp_b));
            end
         end
      end
      p_strb = ext_rd || ext_wr;
      p_addr = ext_addr;
   end

   task automatic decode(input logic [31:0] a, output bit hit, output int idx);
      hit = 1'b0;
      idx = 0;
      for (int i = 6; i >= 0; i--) begin
         if (b_en[i] && (((a ^ b_base[i]) & (32'hFFFF_FFFF << b_szlog[i])) == 32'h0)) begin
            hit = 1'b1;
            idx = i;
         end
      end
   endtask

   task automatic set_win(input int i, input bit en, input logic [31:0] base,
                          input logic [5:0] szl, input logic [3:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(i); cfg_en = en; cfg_base = base;
      cfg_szlog = szl; cfg_wait = w;
      @(negedge clk);
      cfg_we = 1'b0;
      b_en[i] = en; b_base[i] = base; b_szlog[i] = szl; b_wait[i] = w;
   endtask

   task automatic set_width(input bit w16);
      @(negedge clk);
      cfg_width_we = 1'b1; cfg_width16 = w16;
      @(negedge clk);
      cfg_width_we = 1'b0;
      bus16 = w16;
   endtask

   // driver: predicts the sub-accesses, runs the transfer, checks timing and data
   task automatic xfer(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] d, input string req,
                       input bit mid, input int mid_idx, input logic [3:0] mid_wait);
      bit hit;
      int idx, wt, nb, nby, lat, cyc;
      logic [31:0] expd;
      beat_t b;
      decode(a, hit, idx);
      nby  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      wt   = hit ? int'(b_wait[idx]) : 15;
      nb   = !hit ? 1 : (bus16 ? ((nby == 4) ? 2 : 1) : nby);
      lat  = nb * (wt + 1) + 1;
      expd = '0;
      if (hit) for (int k = 0; k < nby; k++) expd |= 32'(byte_at(a + 32'(k))) << (8 * k);
      if (hit) begin
         for (int k = 0; k < nb; k++) begin
            b.cs = 7'(1) << idx;
            b.wr = wr;
            if (!bus16) begin
               b.addr = a + 32'(k); b.be = 2'b01;
               b.data = wr ? {8'h00, d[8*k +: 8]} : 16'h0;
            end else if (nby == 1) begin
               b.addr = a; b.be = a[0] ? 2'b10 : 2'b01;
               b.data = wr ? (a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]}) : 16'h0;
            end else begin
               b.addr = a + 32'(2 * k); b.be = 2'b11;
               b.data = wr ? d[16*k +: 16] : 16'h0;
            end
            exp_q.push_back(b);
         end
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
      cyc = 0;
      while (!cpu_ready && cyc < 200) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (mid && cyc == 2) begin
            cfg_we = 1'b1; cfg_idx = 3'(mid_idx); cfg_en = b_en[mid_idx];
            cfg_base = b_base[mid_idx]; cfg_szlog = b_szlog[mid_idx]; cfg_wait = mid_wait;
            b_wait[mid_idx] = mid_wait;
         end else begin
            cfg_we = 1'b0;
         end
      end
      cfg_we = 1'b0;
      chk(cyc == lat, req, "edges to ready", 64'(cyc), 64'(lat));
      chk(ext_cs == 7'h0, "R9", "chip-select during ready", 64'(ext_cs), 64'h0);
      if (!wr) chk(cpu_rdata == expd, req, "read data", 64'(cpu_rdata), 64'(expd));
      cpu_req = 1'b0;
      @(negedge clk);
      chk(!cpu_ready, "R9", "ready width", 64'(cpu_ready), 64'h0);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 7; i++) begin
         b_en[i] = (i == 0); b_base[i] = '0;
         b_szlog[i] = (i == 0) ? 6'd16 : 6'd0; b_wait[i] = (i == 0) ? 4'd2 : 4'hF;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3: quiet outputs after reset
      chk(ext_cs == 7'h0 && !ext_rd && !ext_wr && !cpu_ready, "R3", "reset outputs",
          64'({ext_cs, ext_rd, ext_wr, cpu_ready}), 64'h0);
      // R3 boot window, R6 8-bit split, R8 assembly
      xfer(1'b0, 2'd2, 32'h0000_0010, 32'h0, "R3", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd0, 32'h0000_0123, 32'h0, "R8", 1'b0, 0, 4'h0);
      // R10 unmatched read and write
      xfer(1'b0, 2'd2, 32'h0002_0000, 32'h0, "R10", 1'b0, 0, 4'h0);
      xfer(1'b1, 2'd1, 32'h0004_0000, 32'h1234, "R10", 1'b0, 0, 4'h0);
      // overlapping windows 1 and 2, window 3 with wait 5
      set_win(1, 1'b1, 32'h1000_0000, 6'd12, 4'd0);
      set_win(2, 1'b1, 32'h1000_0000, 6'd16, 4'd3);
      set_win(3, 1'b1, 32'h2000_0000, 6'd8,  4'd5);
      xfer(1'b1, 2'd2, 32'h1000_0100, 32'h1122_3344, "R5", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd1, 32'h2000_0002, 32'h0, "R4", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd2, 32'h1000_0000, 32'h0, "R2", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd2, 32'h1000_2000, 32'h0, "R2", 1'b0, 0, 4'h0);
      // 16-bit bus
      set_width(1'b1);
      xfer(1'b1, 2'd2, 32'h1000_0040, 32'hCAFE_F00D, "R7", 1'b0, 0, 4'h0);
      xfer(1'b1, 2'd0, 32'h1000_0005, 32'h0000_00AB, "R7", 1'b0, 0, 4'h0);
      xfer(1'b1, 2'd0, 32'h1000_0006, 32'h0000_00CD, "R7", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd0, 32'h1000_0007, 32'h0, "R8", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd1, 32'h2000_0010, 32'h0, "R4", 1'b0, 0, 4'h0);
      xfer(1'b0, 2'd2, 32'h1000_0080, 32'h0, "R8", 1'b0, 0, 4'h0);
      // R11: reprogram window 3 mid-transfer, then the next transfer sees it
      xfer(1'b0, 2'd2, 32'h2000_0020, 32'h0, "R11", 1'b1, 3, 4'd0);
      xfer(1'b0, 2'd2, 32'h2000_0020, 32'h0, "R11", 1'b0, 0, 4'h0);
      // R1: disabled window no longer matches, window 2 takes over
      set_win(1, 1'b0, 32'h1000_0000, 6'd12, 4'd0);
      xfer(1'b0, 2'd1, 32'h1000_0010, 32'h0, "R1", 1'b0, 0, 4'h0);
      xfer(1'b1, 2'd1, 32'h1000_0012, 32'h0000_BEEF, "R1", 1'b0, 0, 4'h0);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "sub-accesses left unseen", 64'(exp_q.size()), 64'h0);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule